// File: doc/BRIEF.md
# Program Counter Sequencer with Branch and Jump Targets

This block owns the fetch address of a 32-bit core that uses fixed four-byte, word-aligned instructions. In every cycle it looks at the instruction word held for the current address. It forms two candidate destinations from that word. The first is a PC-relative branch destination: a signed 16-bit word displacement counted from the address that follows the branch. The second is an absolute jump destination, built from a 26-bit word index.

A register compare elsewhere in the core supplies `ops_equal`. The block uses it to decide whether an equal-compare or not-equal-compare branch is taken. A separate `jump_sel` request forces the absolute jump. A stall freezes the address, and a synchronous reset returns it to the boot address.

Both candidate destinations are driven as outputs every cycle, whichever one is chosen. Neighbouring logic can therefore use them for prediction checks or debug.

Top module: `pc_sequencer`

## Requirements
- R1: With `rst` high at a rising clock edge, `pc` becomes 0x00400000 at that edge, whatever `stall`, `jump_sel` or the instruction are.
- R2: With `rst`, `stall` and `jump_sel` low and no taken branch, `pc` advances by 4 at the edge.
- R3: With `stall` high and `rst` low, `pc` keeps its value at the edge, even when a jump or a taken branch is requested.
- R4: `branch_target` always equals `pc` + 4 + 4 × (instr[15:0] read as a two's-complement word count), so a value of 0xFFFF yields `pc` itself.
- R5: Opcode instr[31:26] = 6'h04 is an equal-compare branch: with `ops_equal` high (and no stall or jump), `pc` takes `branch_target`; with `ops_equal` low, it steps by 4.
- R6: Opcode 6'h05 is a not-equal-compare branch: with `ops_equal` low it is taken to `branch_target`; with `ops_equal` high, `pc` steps by 4.
- R7: `jump_target` always equals {bits [31:28] of `pc` + 4, instr[25:0], 2'b00}, so the upper nibble comes from the following address even when that address crosses a 256 MB boundary.
- R8: With `jump_sel` high (no stall or reset), `pc` takes `jump_target`, ahead of any taken branch.
- R9: Any opcode other than 6'h04 and 6'h05, including the jump opcode 6'h02, leaves `pc` on the sequential path when `jump_sel` is low, whatever `ops_equal` is.
- R10: Bits [1:0] of `pc`, `branch_target` and `jump_target` are always 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds the fetch address this cycle |
| jump_sel | input | 1 | Requests the absolute jump destination |
| ops_equal | input | 1 | The two compared register operands are equal |
| instr | input | 32 | Instruction word at the current address |
| pc | output | 32 | Current fetch address |
| branch_target | output | 32 | PC-relative branch destination |
| jump_target | output | 32 | Absolute jump destination |

## Verification
The bench aims at a displacement of -1. A design that measured from the branch's own address instead of the next one would jump four bytes back rather than loop on itself. It also checks forward and backward displacements, where missing sign extension would send the backward case about 256 KB forward.

A jump issued from 0x0FFFFFFC must take its upper nibble from the following address, 0x1. A design that took it from the current address would land in the lower segment. The bench also raises `jump_sel` together with a taken branch, where a reversed priority would show up as a branch destination. Finally, it raises stall or reset together with a redirect, where a design that let the redirect through would move the address.

// File: rtl/pc_sequencer_pkg.sv
package pc_sequencer_pkg;

   // Opcode values decoded by the sequencer (instruction bits [31:26])
   localparam int OPC_JUMP_CODE = 2;
   localparam int OPC_BEQ_CODE  = 4;
   localparam int OPC_BNE_CODE  = 5;

   // Source of the next fetch address
   typedef enum logic [1:0] {
      NXT_SEQ    = 2'd0,
      NXT_BRANCH = 2'd1,
      NXT_JUMP   = 2'd2,
      NXT_HOLD   = 2'd3
   } nxt_src_e;

endpackage

// File: rtl/pc_target_calc.sv
module pc_target_calc #(
   parameter int XLEN         = 32,
   parameter int IMM_W        = 16,
   parameter int JIDX_W       = 26,
   parameter bit PARALLEL_ADD = 1'b0
) (
   input  logic [XLEN-1:0]   pc,
   input  logic [IMM_W-1:0]  imm,
   input  logic [JIDX_W-1:0] jidx,
   output logic [XLEN-1:0]   pc_plus4,
   output logic [XLEN-1:0]   br_target,
   output logic [XLEN-1:0]   j_target
);

   localparam int             SEXT_W = XLEN - IMM_W;
   localparam int             UP_W   = XLEN - JIDX_W - 2;
   localparam logic [XLEN-1:0] STEP  = XLEN'(4);

   logic [XLEN-1:0] off_words;
   logic [XLEN-1:0] off_bytes;

   if (SEXT_W < 2) begin : g_bad_imm
      $error("pc_target_calc: IMM_W leaves no room for word scaling");
   end
   if (UP_W < 0) begin : g_bad_jidx
      $error("pc_target_calc: JIDX_W too wide for XLEN");
   end

   assign pc_plus4  = pc + STEP;
   assign off_words = {{SEXT_W{imm[IMM_W-1]}}, imm};
   assign off_bytes = off_words << 2;

   // Variant: chained adder after the increment, or an adder tree that
   // folds the constant 4 into the displacement so both adds overlap.
   if (PARALLEL_ADD) begin : g_parallel
      logic [XLEN-1:0] off_plus4;
      assign off_plus4 = off_bytes + STEP;
      assign br_target = pc + off_plus4;
   end else begin : g_chain
      assign br_target = pc_plus4 + off_bytes;
   end

   if (UP_W > 0) begin : g_upper
      assign j_target = {pc_plus4[XLEN-1 -: UP_W], jidx, 2'b00};
   end else begin : g_flat
      assign j_target = {jidx, 2'b00};
   end

   always_comb begin
      AST_BR_TARGET_ALIGNED : assert (br_target[1:0] == 2'b00 || $isunknown(pc)); // R10
   end

endmodule

// File: rtl/pc_next_decide.sv
module pc_next_decide
   import pc_sequencer_pkg::*;
#(
   parameter int OPC_W = 6
) (
   input  logic [OPC_W-1:0] opcode,
   input  logic             ops_equal,
   input  logic             jump_sel,
   input  logic             stall,
   output logic             br_taken,
   output nxt_src_e         nxt_src
);

   localparam logic [OPC_W-1:0] OPC_BEQ = OPC_W'(OPC_BEQ_CODE);
   localparam logic [OPC_W-1:0] OPC_BNE = OPC_W'(OPC_BNE_CODE);

   if (OPC_W < 3) begin : g_bad_opc
      $error("pc_next_decide: OPC_W too narrow for the branch opcodes");
   end

   logic is_beq;
   logic is_bne;

   assign is_beq = (opcode == OPC_BEQ);
   assign is_bne = (opcode == OPC_BNE);

   always_comb begin
      br_taken = (is_beq && ops_equal) || (is_bne && !ops_equal);
      if (stall) begin
         nxt_src = NXT_HOLD;
      end else if (jump_sel) begin
         nxt_src = NXT_JUMP;
      end else if (br_taken) begin
         nxt_src = NXT_BRANCH;
      end else begin
         nxt_src = NXT_SEQ;
      end
   end

endmodule

// File: rtl/pc_state_reg.sv
module pc_state_reg
   import pc_sequencer_pkg::*;
#(
   parameter int              XLEN     = 32,
   parameter logic [XLEN-1:0] RESET_PC = XLEN'(32'h0040_0000)
) (
   input  logic            clk,
   input  logic            rst,
   input  nxt_src_e        nxt_src,
   input  logic [XLEN-1:0] pc_plus4,
   input  logic [XLEN-1:0] br_target,
   input  logic [XLEN-1:0] j_target,
   output logic [XLEN-1:0] pc_q
);

   if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset
      $error("pc_state_reg: RESET_PC must be word aligned");
   end

   logic [XLEN-1:0] pc_d;

   always_comb begin
      unique case (nxt_src)
         NXT_JUMP:   pc_d = j_target;
         NXT_BRANCH: pc_d = br_target;
         NXT_HOLD:   pc_d = pc_q;
         default:    pc_d = pc_plus4;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= RESET_PC;
      end else begin
         pc_q <= pc_d;
      end
   end

   AST_RESET_LOAD : assert property (@(posedge clk)
      rst |=> pc_q == RESET_PC); // R1

   AST_STALL_HOLD : assert property (@(posedge clk) disable iff (rst)
      (nxt_src == NXT_HOLD) |=> pc_q == $past(pc_q)); // R3

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
   parameter int              XLEN         = 32,
   parameter int              INSTR_W      = 32,
   parameter int              OPC_W        = 6,
   parameter int              IMM_W        = 16,
   parameter int              JIDX_W       = 26,
   parameter bit              PARALLEL_ADD = 1'b0,
   parameter logic [XLEN-1:0] RESET_PC     = XLEN'(32'h0040_0000)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               stall,
   input  logic               jump_sel,
   input  logic               ops_equal,
   input  logic [INSTR_W-1:0] instr,
   output logic [XLEN-1:0]    pc,
   output logic [XLEN-1:0]    branch_target,
   output logic [XLEN-1:0]    jump_target
);

   import pc_sequencer_pkg::*;

   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   if (INSTR_W != OPC_W + JIDX_W) begin : g_bad_fields
      $error("pc_sequencer: opcode and jump index must tile the instruction");
   end
   if (IMM_W > JIDX_W) begin : g_bad_imm
      $error("pc_sequencer: immediate must sit inside the jump index field");
   end

   logic [OPC_W-1:0]  opcode;
   logic [IMM_W-1:0]  imm;
   logic [JIDX_W-1:0] jidx;
   logic [XLEN-1:0]   pc_plus4;
   logic              br_taken;
   nxt_src_e          nxt_src;

   assign opcode = instr[INSTR_W-1 -: OPC_W];
   assign jidx   = instr[JIDX_W-1:0];
   assign imm    = instr[IMM_W-1:0];

   pc_target_calc #(
      .XLEN         (XLEN),
      .IMM_W        (IMM_W),
      .JIDX_W       (JIDX_W),
      .PARALLEL_ADD (PARALLEL_ADD)
   ) u_calc (
      .pc        (pc),
      .imm       (imm),
      .jidx      (jidx),
      .pc_plus4  (pc_plus4),
      .br_target (branch_target),
      .j_target  (jump_target)
   );

   pc_next_decide #(
      .OPC_W (OPC_W)
   ) u_decide (
      .opcode    (opcode),
      .ops_equal (ops_equal),
      .jump_sel  (jump_sel),
      .stall     (stall),
      .br_taken  (br_taken),
      .nxt_src   (nxt_src)
   );

   pc_state_reg #(
      .XLEN     (XLEN),
      .RESET_PC (RESET_PC)
   ) u_reg (
      .clk       (clk),
      .rst       (rst),
      .nxt_src   (nxt_src),
      .pc_plus4  (pc_plus4),
      .br_target (branch_target),
      .j_target  (jump_target),
      .pc_q      (pc)
   );

   AST_SEQ_STEP : assert property (@(posedge clk) disable iff (rst)
      (!stall && !jump_sel && !br_taken) |=> pc == $past(pc) + STEP); // R2

   AST_BRANCH_REDIRECT : assert property (@(posedge clk) disable iff (rst)
      (!stall && !jump_sel && br_taken) |=> pc == $past(branch_target)); // R5

   AST_JUMP_REDIRECT : assert property (@(posedge clk) disable iff (rst)
      (!stall && jump_sel) |=> pc == $past(jump_target)); // R8

   AST_PC_ALIGNED : assert property (@(posedge clk) disable iff (rst)
      pc[1:0] == 2'b00); // R10

endmodule

// File: tb/pc_sequencer_bench.sv
`timescale 1ns/1ps
module pc_sequencer_bench;

   localparam logic [31:0] BOOT = 32'h0040_0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        stall = 1'b0;
   logic        jump_sel = 1'b0;
   logic        ops_equal = 1'b0;
   logic [31:0] instr = 32'h0;
   logic [31:0] pc;
   logic [31:0] branch_target;
   logic [31:0] jump_target;

   int          n_checks = 0;
   int          n_fail   = 0;
   logic [31:0] m_pc;

   always #2 clk = ~clk;

   pc_sequencer u_pc_sequencer (
      .clk           (clk),
      .rst           (rst),
      .stall         (stall),
      .jump_sel      (jump_sel),
      .ops_equal     (ops_equal),
      .instr         (instr),
      .pc            (pc),
      .branch_target (branch_target),
      .jump_target   (jump_target)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_br(input logic [5:0] opc, input logic [15:0] off);
      return {opc, 5'd8, 5'd9, off};
   endfunction

   function automatic logic [31:0] mk_j(input logic [25:0] idx);
      return {6'h02, idx};
   endfunction

   // One cycle: drive at negedge, check targets, let the edge pass, check pc.
   task automatic step(input logic [31:0] ins, input logic eq, input logic js, input logic st);
      int          off;
      logic [31:0] exp_bt;
      logic [31:0] exp_jt;
      logic [31:0] nxt;
      logic [31:0] seq;
      string       tag;
      instr = ins; ops_equal = eq; jump_sel = js; stall = st;
      #1;
      seq    = m_pc + 32'd4;
      off    = $signed(ins[15:0]);
      exp_bt = seq + 32'(off * 4);
      exp_jt = {seq[31:28], ins[25:0], 2'b00};
      check(branch_target, exp_bt, "R4");
      check(jump_target, exp_jt, "R7");
      check({30'd0, branch_target[1:0]} | {30'd0, jump_target[1:0]}, 32'd0, "R10");
      if (st) begin
         nxt = m_pc; tag = "R3";
      end else if (js) begin
         nxt = exp_jt; tag = "R8";
      end else if (ins[31:26] == 6'h04) begin
         nxt = eq ? exp_bt : seq; tag = "R5";
      end else if (ins[31:26] == 6'h05) begin
         nxt = eq ? seq : exp_bt; tag = "R6";
      end else begin
         nxt = seq; tag = (ins[31:26] == 6'h00) ? "R2" : "R9";
      end
      @(posedge clk);
      m_pc = nxt;
      @(negedge clk);
      check(pc, m_pc, tag);
      check({30'd0, pc[1:0]}, 32'd0, "R10");
   endtask

   task automatic do_reset(input logic st, input logic js);
      rst = 1'b1; stall = st; jump_sel = js; ops_equal = 1'b1;
      instr = mk_br(6'h04, 16'h0010);
      @(posedge clk);
      m_pc = BOOT;
      @(negedge clk);
      check(pc, BOOT, "R1");
      rst = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      m_pc = BOOT;
      @(negedge clk);
      do_reset(1'b0, 1'b0);                         // R1 plain reset
      step(32'h0000_0020, 1'b0, 1'b0, 1'b0);       // R2 sequential
      step(32'h0000_0020, 1'b1, 1'b0, 1'b0);       // R2
      step(mk_br(6'h04, 16'h0003), 1'b1, 1'b0, 1'b0); // R5 forward taken
      step(mk_br(6'h04, 16'h0003), 1'b0, 1'b0, 1'b0); // R5 not taken
      step(mk_br(6'h05, 16'hFFFE), 1'b0, 1'b0, 1'b0); // R6 backward taken
      step(mk_br(6'h05, 16'hFFFE), 1'b1, 1'b0, 1'b0); // R6 not taken
      for (int i = 0; i < 3; i++)
         step(mk_br(6'h04, 16'hFFFF), 1'b1, 1'b0, 1'b0); // R4 branch to itself
      step(mk_br(6'h04, 16'h7FFF), 1'b1, 1'b0, 1'b0); // R4 largest forward
      step(mk_br(6'h05, 16'h8000), 1'b0, 1'b0, 1'b0); // R4 largest backward
      step(mk_j(26'h000_1234), 1'b1, 1'b1, 1'b1);  // R3 stall beats jump
      step(mk_br(6'h04, 16'h0040), 1'b1, 1'b0, 1'b1); // R3 stall beats branch
      step(mk_br(6'h05, 16'h0040), 1'b0, 1'b1, 1'b0); // R8 jump beats taken branch
      step(mk_j(26'h3FF_FFFF), 1'b0, 1'b1, 1'b0);  // R7 land at 0x0FFFFFFC
      check(pc, 32'h0FFF_FFFC, "R7");
      step(mk_j(26'h000_0010), 1'b0, 1'b1, 1'b0);  // R7 upper nibble wraps to 1
      check(pc, 32'h1000_0040, "R7");
      step(mk_j(26'h000_0100), 1'b1, 1'b0, 1'b0);  // R9 jump opcode, no select
      step(32'h1800_0004, 1'b1, 1'b0, 1'b0);       // R9 opcode 0x06
      step(32'h1C00_0004, 1'b0, 1'b0, 1'b0);       // R9 opcode 0x07
      do_reset(1'b1, 1'b1);                         // R1 reset beats stall and jump
      for (int i = 0; i < 600; i++) begin
         logic [31:0] r;
         logic [5:0]  opc;
         r = $urandom;
         case ($urandom_range(0, 5))
            0: opc = 6'h04;
            1: opc = 6'h05;
            2: opc = 6'h02;
            3: opc = 6'h00;
            default: opc = 6'($urandom);
         endcase
         step({opc, r[25:0]}, 1'($urandom), ($urandom_range(0, 7) == 0),
              ($urandom_range(0, 5) == 0));
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule